// File: doc/BRIEF.md
# SPI Slave Receive Path with Overflow Lockout

This block receives serial words from an external SPI master and hands them to a CPU through one receive data register. The master's clock, data and active-low select pins are brought into the system clock domain through two-flop synchronizers. The block samples data on the synchronized rising edge of the serial clock, most significant bit first. The word length can be set from 2 to 16 bits. The system clock must run at least four times as fast as the serial clock.

The block decides a receive overflow early. If the receive register still holds an unread word when the second-to-last bit of the next word is sampled, the overflow flag sets. From then on, completed words are thrown away and the held word stays readable. The flag clears only when the CPU reads the status register, sees the flag set, and then reads the data register.

A mode-fault flag reports a select level that does not fit the configured mode, and only while its enable is high. One interrupt output combines the receive-full condition with the error condition, and each has its own enable.

Top module: `spi_rx_ovf`

## Requirements
- R1: After reset the receive-full flag (status bit 0), the overflow flag (status bit 1), the mode-fault flag (status bit 2) and `irq_o` are all 0.
- R2: In slave mode (`slave_mode_i`=1) with `ss_ni` low, one bit of `mosi_i` is captured on each rising edge of `sclk_i`, most significant bit first. A word is `cfg_len_i`+1 bits long; a value of 0 is treated as 1. When a word completes while no overflow is set, it is loaded right-aligned into the data register (address 1) and receive-full sets.
- R3: At the capture of the second-to-last bit of a word (received count equal to word length minus one), the overflow flag sets if receive-full is 1 at that moment.
- R4: While the overflow flag is 1, completed words are not loaded, receive-full is not set by them, and the word already in the data register stays unchanged.
- R5: The overflow flag clears only on a data read (`rd_en_i`=1, `rd_addr_i`=1) that comes after a status read (`rd_addr_i`=0) which saw the flag set. A data read without such a prior status read leaves the flag set. This includes the case where the flag set between the status read and the data read.
- R6: A data read clears receive-full.
- R7: The mode-fault flag never sets while `mf_en_i` is 0. While `mf_en_i` is 1 and `slave_mode_i` is 0, a low `ss_ni` sets it. It clears by the same status-then-data read sequence as the overflow flag.
- R8: `irq_o` = (`rx_ie_i` AND receive-full) OR (`err_ie_i` AND (overflow OR mode-fault)); one enable covers both error flags.
- R9: Raising `ss_ni` in the middle of a word discards the partial word and restarts the bit count. Neither flag changes, and the next word is received from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_ni | input | 1 | Active-low slave select |
| slave_mode_i | input | 1 | 1 = slave mode; receive is active only here |
| cfg_len_i | input | 4 | Word length minus one |
| mf_en_i | input | 1 | Mode-fault detection enable |
| rx_ie_i | input | 1 | Receive-full interrupt enable |
| err_ie_i | input | 1 | Shared error interrupt enable |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 1 | 0 = status, 1 = data |
| rd_data_o | output | 16 | Read data for the addressed register |
| irq_o | output | 1 | Combined receive/error interrupt |

## Verification
Assertions check on every cycle that:
- the overflow flag rises only at a second-to-last-bit capture while receive-full is set;
- the data register holds still when a word completes under overflow;
- the overflow flag falls only on a data read after a status read that saw it set;
- a data read clears receive-full;
- a disabled mode-fault flag stays clear;
- a dropped select zeroes the bit count.

Only the bench scenarios can show the rest: correct word contents at 2, 8 and 16 bits; the lost-word sequence across several words; the race where the flag sets between the two reads; recovery after an aborted word; and the interrupt gating.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int unsigned STAT_FULL = 0;
  localparam int unsigned STAT_OVF  = 1;
  localparam int unsigned STAT_MF   = 2;
  localparam logic        ADDR_STATUS = 1'b0;
  localparam logic        ADDR_DATA   = 1'b1;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [2:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {3{RST_VAL[g]}};
      else         pipe_q <= {pipe_q[1:0], async_i[g]};
    end
    assign sync_o[g] = pipe_q[1];
    assign prev_o[g] = pipe_q[2];
  end
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int unsigned MAX_W = 16,
  localparam int unsigned CW = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ss_act_i,
  input  logic             smp_i,
  input  logic             mosi_i,
  input  logic [CW-1:0]    len_m1_i,
  output logic             pen_o,
  output logic             done_o,
  output logic [MAX_W-1:0] word_o
);
  logic [CW-1:0]    cnt_q;
  logic [MAX_W-1:0] shift_q, shift_d, mask;
  logic [CW-1:0]    len_eff;
  logic             take;

  assign len_eff = (len_m1_i == '0) ? CW'(1) : len_m1_i;
  assign take    = smp_i & ss_act_i;
  assign shift_d = {shift_q[MAX_W-2:0], mosi_i};

  for (genvar g = 0; g < MAX_W; g++) begin : g_mask
    assign mask[g] = (CW'(g) <= len_eff) || (g == 0);
  end

  // bit index 1 capture: count reaches length minus one
  assign pen_o  = take && (cnt_q == len_eff - CW'(1));
  assign done_o = take && (cnt_q == len_eff);
  assign word_o = shift_d & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (!ss_act_i) begin
      cnt_q   <= '0;
    end else if (take) begin
      shift_q <= shift_d;
      cnt_q   <= done_o ? '0 : cnt_q + CW'(1);
    end
  end

  a_r9_abort_zeroes_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_act_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags #(
  parameter int unsigned MAX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pen_i,
  input  logic             done_i,
  input  logic [MAX_W-1:0] word_i,
  input  logic             stat_rd_i,
  input  logic             data_rd_i,
  input  logic             mf_cond_i,
  output logic             full_o,
  output logic             ovf_o,
  output logic             mf_o,
  output logic [MAX_W-1:0] rx_o
);
  logic full_q, ovf_q, mf_q, ovf_arm_q, mf_arm_q;
  logic [MAX_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q    <= 1'b0;
      ovf_q     <= 1'b0;
      mf_q      <= 1'b0;
      ovf_arm_q <= 1'b0;
      mf_arm_q  <= 1'b0;
      rx_q      <= '0;
    end else begin
      // arm only for flags seen set by a status read
      if (stat_rd_i) begin
        ovf_arm_q <= ovf_q;
        mf_arm_q  <= mf_q;
      end else if (data_rd_i) begin
        ovf_arm_q <= 1'b0;
        mf_arm_q  <= 1'b0;
      end
      if (pen_i && full_q)             ovf_q <= 1'b1;
      else if (data_rd_i && ovf_arm_q) ovf_q <= 1'b0;
      if (mf_cond_i)                   mf_q <= 1'b1;
      else if (data_rd_i && mf_arm_q)  mf_q <= 1'b0;
      if (done_i && !ovf_q) begin
        full_q <= 1'b1;
        rx_q   <= word_i;
      end else if (data_rd_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o = full_q;
  assign ovf_o  = ovf_q;
  assign mf_o   = mf_q;
  assign rx_o   = rx_q;

  a_r3_ovf_only_at_pen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(pen_i && full_q));
  a_r4_hold_under_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && done_i) |=> $stable(rx_q));
  a_r5_clear_needs_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_q) |-> $past(data_rd_i && ovf_arm_q));
  a_r6_data_read_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && !done_i) |=> !full_q);
endmodule

// File: rtl/spi_rx_ovf.sv
module spi_rx_ovf
  import spi_rx_pkg::*;
#(
  parameter int unsigned MAX_W = 16,
  localparam int unsigned CW = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             mosi_i,
  input  logic             ss_ni,
  input  logic             slave_mode_i,
  input  logic [CW-1:0]    cfg_len_i,
  input  logic             mf_en_i,
  input  logic             rx_ie_i,
  input  logic             err_ie_i,
  input  logic             rd_en_i,
  input  logic             rd_addr_i,
  output logic [MAX_W-1:0] rd_data_o,
  output logic             irq_o
);
  logic [2:0] pin_s, pin_p;
  logic ss_act, smp, pen, done, full, ovf, mf, mf_cond;
  logic [MAX_W-1:0] word, rx;

  spi_rx_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
    .clk_i, .rst_ni,
    .async_i ({ss_ni, mosi_i, sclk_i}),
    .sync_o  (pin_s),
    .prev_o  (pin_p)
  );

  assign ss_act  = slave_mode_i & ~pin_s[2];
  assign smp     = pin_s[0] & ~pin_p[0];
  assign mf_cond = mf_en_i & ~slave_mode_i & ~pin_s[2];

  spi_rx_shift #(.MAX_W(MAX_W)) i_shift (
    .clk_i, .rst_ni,
    .ss_act_i (ss_act),
    .smp_i    (smp),
    .mosi_i   (pin_s[1]),
    .len_m1_i (cfg_len_i),
    .pen_o    (pen),
    .done_o   (done),
    .word_o   (word)
  );

  spi_rx_flags #(.MAX_W(MAX_W)) i_flags (
    .clk_i, .rst_ni,
    .pen_i     (pen),
    .done_i    (done),
    .word_i    (word),
    .stat_rd_i (rd_en_i && rd_addr_i == ADDR_STATUS),
    .data_rd_i (rd_en_i && rd_addr_i == ADDR_DATA),
    .mf_cond_i (mf_cond),
    .full_o    (full),
    .ovf_o     (ovf),
    .mf_o      (mf),
    .rx_o      (rx)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_DATA) begin
      rd_data_o = rx;
    end else begin
      rd_data_o[STAT_FULL] = full;
      rd_data_o[STAT_OVF]  = ovf;
      rd_data_o[STAT_MF]   = mf;
    end
  end

  assign irq_o = (rx_ie_i & full) | (err_ie_i & (ovf | mf));

  a_r7_mf_off_stays_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mf_en_i && !mf) |=> !mf);
endmodule

// File: tb/test_spi_rx_ovf.sv
module test_spi_rx_ovf;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, mosi = 0, ss_n = 1, slave_mode = 1;
  logic [3:0] cfg_len = 4'd7;
  logic mf_en = 0, rx_ie = 0, err_ie = 0, rd_en = 0, rd_addr = 0;
  logic [15:0] rd_data;
  logic irq;

  int vectors = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rx_ovf i_spi_rx_ovf (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi), .ss_ni(ss_n),
    .slave_mode_i(slave_mode), .cfg_len_i(cfg_len), .mf_en_i(mf_en),
    .rx_ie_i(rx_ie), .err_ie_i(err_ie), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  // reference model state
  int m_cnt, m_shift, m_rx;
  bit m_full, m_ovf, m_mf, m_oarm, m_marm;
  bit p1s, p1m, p1ss, p2s, p2m, p2ss, p3s;

  task automatic fail_line(string req, int act, int exp);
    errors++;
    $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_shift = 0; m_rx = 0;
      m_full = 0; m_ovf = 0; m_mf = 0; m_oarm = 0; m_marm = 0;
      p1s = 0; p1m = 0; p1ss = 1; p2s = 0; p2m = 0; p2ss = 1; p3s = 0;
    end else begin
      int len, mask, w;
      bit act, pen, done, srd, drd, mfc, n_ovf, n_mf, n_full;
      len  = (cfg_len == 0) ? 1 : int'(cfg_len);
      mask = (1 << (len + 1)) - 1;
      act  = slave_mode && !p2ss;
      pen = 0; done = 0; w = 0;
      if (act && p2s && !p3s) begin
        w = ((m_shift << 1) | int'(p2m)) & 16'hffff;
        pen  = (m_cnt == len - 1);
        done = (m_cnt == len);
        m_cnt   = done ? 0 : m_cnt + 1;
        m_shift = w;
      end
      if (!act) m_cnt = 0;
      srd = rd_en && !rd_addr;
      drd = rd_en && rd_addr;
      mfc = mf_en && !slave_mode && !p2ss;
      n_ovf = m_ovf;
      if (drd && m_oarm) n_ovf = 0;
      if (pen && m_full) n_ovf = 1;
      n_mf = m_mf;
      if (drd && m_marm) n_mf = 0;
      if (mfc) n_mf = 1;
      n_full = m_full;
      if (drd) n_full = 0;
      if (done && !m_ovf) begin n_full = 1; m_rx = w & mask; end
      if (srd) begin m_oarm = m_ovf; m_marm = m_mf; end
      else if (drd) begin m_oarm = 0; m_marm = 0; end
      m_ovf = n_ovf; m_mf = n_mf; m_full = n_full;
      p3s = p2s; p2s = p1s; p2m = p1m; p2ss = p1ss;
      p1s = sclk; p1m = mosi; p1ss = ss_n;
    end
    #(CLK_PERIOD/4);
    if (rst_n) begin
      vectors++;
      if (irq !== ((rx_ie && m_full) || (err_ie && (m_ovf || m_mf))))
        fail_line("R8 irq", int'(irq), int'((rx_ie && m_full) || (err_ie && (m_ovf || m_mf))));
      if (rd_addr) begin
        if (rd_data !== 16'(m_rx)) fail_line("R2/R4 data register", int'(rd_data), m_rx);
      end else begin
        if (rd_data[0] !== m_full) fail_line("R2/R6 full flag", int'(rd_data[0]), int'(m_full));
        if (rd_data[1] !== m_ovf)  fail_line("R3/R5 overflow flag", int'(rd_data[1]), int'(m_ovf));
        if (rd_data[2] !== m_mf)   fail_line("R7 mode-fault flag", int'(rd_data[2]), int'(m_mf));
        if (rd_data[15:3] !== 13'd0) fail_line("R1 status spare bits", int'(rd_data), 0);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(int val, int len, int nbits);
    ss_n = 0; tick(HALF_SCLK);
    for (int i = 0; i < nbits; i++) begin
      mosi = val[len-1-i];
      sclk = 0; tick(HALF_SCLK);
      sclk = 1; tick(HALF_SCLK);
    end
    sclk = 0; tick(HALF_SCLK);
    ss_n = 1; tick(HALF_SCLK);
  endtask

  task automatic send_word(int val);
    send_bits(val, int'(cfg_len) + 1, int'(cfg_len) + 1);
  endtask

  task automatic rd(bit addr);
    @(negedge clk); rd_addr = addr; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  // explicit check of one register with no side effect (rd_en low)
  task automatic peek(bit addr, int exp, string req);
    @(negedge clk); rd_addr = addr; rd_en = 0;
    @(posedge clk); #(CLK_PERIOD/4);
    vectors++;
    if (rd_data !== 16'(exp)) fail_line(req, int'(rd_data), exp);
  endtask

  initial begin
    tick(4); rst_n = 1; tick(2);
    peek(0, 0, "R1 reset status");
    vectors++; if (irq !== 1'b0) fail_line("R1 reset irq", int'(irq), 0);

    // basic byte receive
    send_word(8'hA5);
    peek(0, 3'b001, "R2 full after word");
    rd(0); rd(1);
    peek(1, 8'hA5, "R2 byte content");
    peek(0, 0, "R6 full cleared by data read");

    // overflow and lockout
    send_word(8'h3C); send_word(8'h81);
    peek(0, 3'b011, "R3 overflow on second word");
    send_word(8'h7E);
    peek(1, 8'h3C, "R4 held word kept");
    rd(1);
    peek(0, 3'b010, "R5 data read alone keeps overflow");
    send_word(8'h44);
    peek(1, 8'h3C, "R4 no load while overflow with empty register");
    peek(0, 3'b010, "R4 full not set under overflow");
    rd(0); rd(1);
    peek(0, 0, "R5 sequence clears overflow");

    // flag sets between status read and data read
    send_word(8'h11);
    rd(0);
    send_word(8'h22);
    rd(1);
    peek(0, 3'b010, "R5 late overflow survives data read");
    rd(0); rd(1);
    peek(0, 0, "R5 clear after fresh status read");

    // overflow decided at second-to-last bit
    send_word(8'h0F);
    send_bits(8'hF0, 8, 6);
    peek(0, 3'b001, "R3 no overflow before bit index 1");
    send_bits(8'hF0, 8, 7);
    peek(0, 3'b011, "R3 overflow at bit index 1 even with aborted word");
    peek(1, 8'h0F, "R9 partial word discarded");
    rd(0); rd(1);

    // shortest and longest words
    cfg_len = 4'd1; tick(2);
    send_word(2'b10);
    peek(1, 2, "R2 two-bit word");
    rd(0); rd(1);
    cfg_len = 4'd15; tick(2);
    send_word(16'hBEEF);
    peek(1, 16'hBEEF, "R2 sixteen-bit word");
    send_bits(16'h1234, 16, 15);
    peek(0, 3'b011, "R3 sixteen-bit overflow at bit index 1");
    rd(0); rd(1);

    // mid-word abort then clean word
    cfg_len = 4'd7; tick(2);
    send_bits(8'hFF, 8, 5);
    peek(0, 0, "R9 abort leaves flags");
    send_word(8'h5A);
    peek(1, 8'h5A, "R9 next word from first bit");

    // interrupt gating
    rx_ie = 1; tick(2);
    vectors++; if (irq !== 1'b1) fail_line("R8 rx irq", int'(irq), 1);
    rx_ie = 0; send_word(8'h99);
    vectors++; if (irq !== 1'b0) fail_line("R8 error irq gated off", int'(irq), 0);
    err_ie = 1; tick(2);
    vectors++; if (irq !== 1'b1) fail_line("R8 error irq", int'(irq), 1);
    rd(0); rd(1); err_ie = 0;

    // mode fault
    slave_mode = 0; ss_n = 0; tick(20);
    peek(0, 0, "R7 disabled mode fault stays clear");
    mf_en = 1; tick(6);
    peek(0, 3'b100, "R7 mode fault sets");
    err_ie = 1; tick(2);
    vectors++; if (irq !== 1'b1) fail_line("R8 mode-fault irq", int'(irq), 1);
    ss_n = 1; mf_en = 0; tick(6);
    slave_mode = 1;
    rd(0); rd(1);
    peek(0, 0, "R7 mode fault cleared");
    err_ie = 0;

    tick(10);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule